// File: doc/BRIEF.md
# Double-Buffered Endpoint Buffer Port

This block is the processor-facing access logic for the endpoint buffers of a USB peripheral. An 8-bit bus carries two kinds of bytes, told apart by one address line: with the line high a written byte is a command, and with it low each read or write is one data-phase byte. A command picks an endpoint and an access mode. The data bytes that follow then move through that endpoint's storage. Each endpoint owns two packet buffers.

In processor mode a packet is carried as a length-prefixed stream. The low length byte comes first, then the high length byte, then the data bytes in order. In DMA mode the stream is raw data. It starts at the primary buffer and rolls on to the secondary buffer when it reaches the end of the primary one. A status command returns one byte per endpoint with its stall, buffer-full, data-toggle, overwrite, setup and current-buffer flags. Reading that byte clears the endpoint's pending interrupt. Stall, unstall and validate commands act on the per-endpoint flags. A USB-side SETUP pulse and per-endpoint completion pulses feed the interrupt and flag logic.

Top module: `epbuf_port`

## Requirements
- R1: A write with `bus_cmd` high is decoded as a command and moves no data. Reads and writes with `bus_cmd` low are data-phase bytes. After reset every status flag and every interrupt bit is 0.
- R2: Command code 00h+n selects endpoint n for processor access. The data phase then carries the length low byte, the length high byte, then data bytes 1..N. Reading after a new select returns the same bytes in the same order from the current buffer.
- R3: Command code 50h+n selects the status of endpoint n. Each data read then returns, bit 7 down to bit 0: stall, buffer 1 full, buffer 0 full, data toggle, overwrite, setup received, current buffer, and 0.
- R4: A pulse on `usb_done[n]` sets `ep_irq[n]`. A status read of endpoint n clears it. When a set and a status read fall in the same cycle, the bit stays set.
- R5: Code 40h+n sets the stall flag of endpoint n and code 60h+n clears it. A `usb_setup` pulse clears the stall flags of endpoints 0 and 1.
- R6: A processor data write sets the full flag of the endpoint's current buffer. Code 20h+n (validate) clears the full flag of the current buffer, toggles the current-buffer bit, and toggles the data toggle.
- R7: Code 10h+n starts a DMA stream for endpoint n at offset 0 of buffer 0. After DEPTH bytes the stream continues at offset 0 of buffer 1. Each byte written sets the full flag of the buffer it lands in.
- R8: Every command byte returns the data-phase sequence to the length-low position, with the data offset at 0.
- R9: No bounds checking is done. The data offset wraps modulo DEPTH inside a buffer, so data byte DEPTH+k overwrites data byte k.
- R10: A `usb_setup` pulse while the processor has endpoint 0 selected and has read at least one data byte sets the overwrite flag of endpoint 0. A status read of endpoint 0 clears both the overwrite flag and the setup flag.
- R11: A `usb_setup` pulse sets the setup flag and the data toggle of endpoint 0, and sets `ep_irq[0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_cmd | input | 1 | Address line: 1 = command byte, 0 = data byte |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_rd | input | 1 | Read strobe, one byte per cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte, combinational while `bus_rd` is high and `bus_cmd` is low, else 0 |
| usb_setup | input | 1 | One-cycle pulse: SETUP packet received on the control endpoint |
| usb_done | input | NUM_EP | One-cycle pulse per endpoint: transaction completed |
| ep_irq | output | NUM_EP | Pending interrupt per endpoint |

## Verification
A read byte is due in the same cycle as its strobe. It is formed combinationally from state updated at earlier edges, so the monitor compares it in the low half of that strobe's cycle, before the committing edge. Flag and interrupt changes, the pointer advance and the clear that a status read causes all take effect at the rising edge that ends the strobe cycle. The bench therefore checks `ep_irq` and later status bytes only from the following falling edge onwards. The driver moves inputs only on falling edges and queues each expected byte as it raises the read strobe, so the monitor's pop always finds the matching entry.

// File: rtl/epbuf_pkg.sv
package epbuf_pkg;

  localparam int EP_W = 4;

  typedef enum logic [2:0] {
    CK_NONE,
    CK_SEL_CPU,
    CK_SEL_DMA,
    CK_VALID,
    CK_STALL,
    CK_UNSTALL,
    CK_STAT
  } cmd_kind_e;

  typedef enum logic [1:0] {
    MD_IDLE,
    MD_CPU,
    MD_DMA,
    MD_STAT
  } mode_e;

  typedef enum logic [1:0] {
    PH_LEN_LO,
    PH_LEN_HI,
    PH_DATA
  } phase_e;

  typedef struct packed {
    cmd_kind_e       kind;
    logic [EP_W-1:0] ep;
  } cmd_t;

endpackage

// File: rtl/epbuf_cmd_dec.sv
module epbuf_cmd_dec
  import epbuf_pkg::*;
#(
  parameter int NUM_EP = 16
) (
  input  logic [7:0] code,
  output cmd_t       cmd
);

  logic ep_ok;

  // upper nibble picks the operation, lower nibble the endpoint
  always_comb begin
    ep_ok    = (int'(code[3:0]) < NUM_EP);
    cmd.ep   = code[3:0];
    cmd.kind = CK_NONE;
    if (ep_ok) begin
      case (code[7:4])
        4'h0:    cmd.kind = CK_SEL_CPU;
        4'h1:    cmd.kind = CK_SEL_DMA;
        4'h2:    cmd.kind = CK_VALID;
        4'h4:    cmd.kind = CK_STALL;
        4'h5:    cmd.kind = CK_STAT;
        4'h6:    cmd.kind = CK_UNSTALL;
        default: cmd.kind = CK_NONE;
      endcase
    end
  end

endmodule

// File: rtl/epbuf_store.sv
module epbuf_store
  import epbuf_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int DEPTH  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [EP_W-1:0]          ep,
  input  logic                     buf_sel,
  input  logic [$clog2(DEPTH)-1:0] ptr,
  input  logic                     data_we,
  input  logic                     len_we,
  input  logic                     len_hi,
  input  logic [7:0]               wdata,
  output logic [7:0]               data_out,
  output logic [15:0]              len_out
);

  localparam int SLOTS = NUM_EP * 2;
  localparam int WORDS = SLOTS * DEPTH;

  logic [7:0]  mem_q [WORDS];
  logic [15:0] len_q [SLOTS];
  logic [15:0] len_d;
  int          slot;
  int          word;

  always_comb begin
    slot = int'(ep) * 2 + int'(buf_sel);
    word = slot * DEPTH + int'(ptr);
  end

  // data array: plain storage, no reset
  always_ff @(posedge clk) begin
    if (data_we) begin
      mem_q[word] <= wdata;
    end
  end

  always_comb begin
    len_d = len_q[slot];
    if (len_hi) len_d[15:8] = wdata;
    else        len_d[7:0]  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) len_q[i] <= '0;
    end else if (len_we) begin
      len_q[slot] <= len_d;
    end
  end

  assign data_out = mem_q[word];
  assign len_out  = len_q[slot];

endmodule

// File: rtl/epbuf_ep_state.sv
module epbuf_ep_state (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stall_set,
  input  logic       stall_clr,
  input  logic       setup_evt,
  input  logic       setup_stall_clr,
  input  logic       validate,
  input  logic [1:0] full_set,
  input  logic       stat_rd,
  input  logic       done_evt,
  input  logic       ovr_evt,
  output logic [7:0] status,
  output logic       irq,
  output logic       cur
);

  logic       stall_q, stall_d;
  logic [1:0] full_q, full_d;
  logic       pid_q, pid_d;
  logic       ovr_q, ovr_d;
  logic       setup_q, setup_d;
  logic       cur_q, cur_d;
  logic       irq_q, irq_d;
  logic [1:0] rel_mask;

  always_comb begin
    rel_mask = '0;
    if (validate) rel_mask = cur_q ? 2'b10 : 2'b01;

    stall_d = (stall_q | stall_set) & ~(stall_clr | setup_stall_clr);
    full_d  = (full_q | full_set) & ~rel_mask;
    cur_d   = cur_q ^ validate;
    pid_d   = setup_evt ? 1'b1 : (pid_q ^ validate);

    if (ovr_evt)      ovr_d = 1'b1;
    else if (stat_rd) ovr_d = 1'b0;
    else              ovr_d = ovr_q;

    if (setup_evt)    setup_d = 1'b1;
    else if (stat_rd) setup_d = 1'b0;
    else              setup_d = setup_q;

    // a new event wins over the clear from a status read
    if (done_evt || setup_evt) irq_d = 1'b1;
    else if (stat_rd)          irq_d = 1'b0;
    else                       irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q <= 1'b0;
      full_q  <= 2'b00;
      pid_q   <= 1'b0;
      ovr_q   <= 1'b0;
      setup_q <= 1'b0;
      cur_q   <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      stall_q <= stall_d;
      full_q  <= full_d;
      pid_q   <= pid_d;
      ovr_q   <= ovr_d;
      setup_q <= setup_d;
      cur_q   <= cur_d;
      irq_q   <= irq_d;
    end
  end

  assign status = {stall_q, full_q[1], full_q[0], pid_q, ovr_q, setup_q, cur_q, 1'b0};
  assign irq    = irq_q;
  assign cur    = cur_q;

  AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done_evt || setup_evt) |=> irq_q);  // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !done_evt && !setup_evt) |=> !irq_q);  // R4
  AST_CUR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    validate |=> (cur_q != $past(cur_q)));  // R6
  AST_STALL_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_set && !stall_clr && !setup_stall_clr) |=> stall_q);  // R5
  AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> ovr_q);  // R10

endmodule

// File: rtl/epbuf_port.sv
module epbuf_port
  import epbuf_pkg::*;
#(
  parameter int NUM_EP = 16,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_cmd,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              usb_setup,
  input  logic [NUM_EP-1:0] usb_done,
  output logic [NUM_EP-1:0] ep_irq
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  // reset: asserts at once, releases on the clock
  logic [1:0] rst_pipe;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_i_n = rst_pipe[1];

  logic cmd_wr, dat_wr, dat_rd;
  assign cmd_wr = bus_wr &  bus_cmd;
  assign dat_wr = bus_wr & ~bus_cmd;
  assign dat_rd = bus_rd & ~bus_cmd;

  cmd_t dec;

  epbuf_cmd_dec #(.NUM_EP(NUM_EP)) u_dec (
    .code (bus_wdata),
    .cmd  (dec)
  );

  // sequencer state
  mode_e           mode_q, mode_d;
  phase_e          phase_q, phase_d;
  logic [EP_W-1:0] sel_q, sel_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic            dbuf_q, dbuf_d;
  logic            rdseen_q, rdseen_d;
  logic            dat_any;
  logic [PTR_W-1:0] ptr_inc;

  assign dat_any = dat_wr | dat_rd;
  assign ptr_inc = (ptr_q == PTR_LAST) ? '0 : ptr_q + 1'b1;

  always_comb begin
    mode_d   = mode_q;
    phase_d  = phase_q;
    sel_d    = sel_q;
    ptr_d    = ptr_q;
    dbuf_d   = dbuf_q;
    rdseen_d = rdseen_q;
    if (cmd_wr) begin
      phase_d  = PH_LEN_LO;
      ptr_d    = '0;
      dbuf_d   = 1'b0;
      rdseen_d = 1'b0;
      sel_d    = dec.ep;
      case (dec.kind)
        CK_SEL_CPU: mode_d = MD_CPU;
        CK_SEL_DMA: mode_d = MD_DMA;
        CK_STAT:    mode_d = MD_STAT;
        default:    mode_d = MD_IDLE;
      endcase
    end else if (dat_any) begin
      if (dat_rd) rdseen_d = 1'b1;
      case (mode_q)
        MD_CPU: begin
          case (phase_q)
            PH_LEN_LO: phase_d = PH_LEN_HI;
            PH_LEN_HI: phase_d = PH_DATA;
            default:   ptr_d   = ptr_inc;
          endcase
        end
        MD_DMA: begin
          ptr_d = ptr_inc;
          if (ptr_q == PTR_LAST) dbuf_d = ~dbuf_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      mode_q   <= MD_IDLE;
      phase_q  <= PH_LEN_LO;
      sel_q    <= '0;
      ptr_q    <= '0;
      dbuf_q   <= 1'b0;
      rdseen_q <= 1'b0;
    end else begin
      mode_q   <= mode_d;
      phase_q  <= phase_d;
      sel_q    <= sel_d;
      ptr_q    <= ptr_d;
      dbuf_q   <= dbuf_d;
      rdseen_q <= rdseen_d;
    end
  end

  // per-endpoint flag logic
  logic [7:0]        stat_all [NUM_EP];
  logic [NUM_EP-1:0] cur_all;
  logic              cur_sel;
  logic              acc_buf;
  logic              cpu_ep0_rd;

  assign cur_sel    = cur_all[sel_q];
  assign acc_buf    = (mode_q == MD_DMA) ? dbuf_q : cur_sel;
  assign cpu_ep0_rd = (mode_q == MD_CPU) && (sel_q == '0) && rdseen_q;

  for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
    logic       is_sel, is_cmd;
    logic [1:0] fset;

    assign is_sel = (int'(sel_q) == e);
    assign is_cmd = cmd_wr && (int'(dec.ep) == e);

    always_comb begin
      fset = 2'b00;
      if (dat_wr && is_sel && (mode_q == MD_CPU || mode_q == MD_DMA)) begin
        fset[acc_buf] = 1'b1;
      end
    end

    epbuf_ep_state u_state (
      .clk             (clk),
      .rst_n           (rst_i_n),
      .stall_set       (is_cmd && dec.kind == CK_STALL),
      .stall_clr       (is_cmd && dec.kind == CK_UNSTALL),
      .setup_evt       ((e == 0) && usb_setup),
      .setup_stall_clr ((e < 2) && usb_setup),
      .validate        (is_cmd && dec.kind == CK_VALID),
      .full_set        (fset),
      .stat_rd         (dat_rd && is_sel && mode_q == MD_STAT),
      .done_evt        (usb_done[e]),
      .ovr_evt         ((e == 0) && usb_setup && cpu_ep0_rd),
      .status          (stat_all[e]),
      .irq             (ep_irq[e]),
      .cur             (cur_all[e])
    );
  end

  // buffer storage
  logic        data_we, len_we;
  logic [7:0]  mem_rd;
  logic [15:0] len_rd;

  assign data_we = dat_wr && ((mode_q == MD_CPU && phase_q == PH_DATA) || mode_q == MD_DMA);
  assign len_we  = dat_wr && mode_q == MD_CPU && phase_q != PH_DATA;

  epbuf_store #(.NUM_EP(NUM_EP), .DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .ep       (sel_q),
    .buf_sel  (acc_buf),
    .ptr      (ptr_q),
    .data_we  (data_we),
    .len_we   (len_we),
    .len_hi   (phase_q == PH_LEN_HI),
    .wdata    (bus_wdata),
    .data_out (mem_rd),
    .len_out  (len_rd)
  );

  always_comb begin
    bus_rdata = 8'h00;
    if (dat_rd) begin
      case (mode_q)
        MD_STAT: bus_rdata = stat_all[sel_q];
        MD_DMA:  bus_rdata = mem_rd;
        MD_CPU: begin
          case (phase_q)
            PH_LEN_LO: bus_rdata = len_rd[7:0];
            PH_LEN_HI: bus_rdata = len_rd[15:8];
            default:   bus_rdata = mem_rd;
          endcase
        end
        default: bus_rdata = 8'h00;
      endcase
    end
  end

  AST_CMD_RESTART: assert property (@(posedge clk) disable iff (!rst_i_n)
    cmd_wr |=> (phase_q == PH_LEN_LO && ptr_q == '0));  // R8
  AST_DMA_ROLL: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dat_any && !cmd_wr && mode_q == MD_DMA && ptr_q == PTR_LAST)
      |=> (ptr_q == '0 && dbuf_q != $past(dbuf_q)));  // R7
  AST_DATA_WRAP: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dat_any && !cmd_wr && mode_q == MD_CPU && phase_q == PH_DATA && ptr_q == PTR_LAST)
      |=> (ptr_q == '0));  // R9
  AST_STAT_BIT0: assert property (@(posedge clk) disable iff (!rst_i_n)
    (dat_rd && mode_q == MD_STAT) |-> (bus_rdata[0] == 1'b0));  // R3

endmodule

// File: tb/epbuf_port_test.sv
module epbuf_port_test;

  localparam int NUM_EP = 16;
  localparam int DEPTH  = 8;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              bus_cmd, bus_wr, bus_rd;
  logic [7:0]        bus_wdata;
  logic [7:0]        bus_rdata;
  logic              usb_setup;
  logic [NUM_EP-1:0] usb_done;
  logic [NUM_EP-1:0] ep_irq;

  int checks = 0;
  int fails  = 0;
  bit over   = 1'b0;

  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;  // 50 MHz

  epbuf_port #(.NUM_EP(NUM_EP), .DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .bus_cmd(bus_cmd), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .usb_setup(usb_setup),
    .usb_done(usb_done), .ep_irq(ep_irq)
  );

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: compares each data read in the low half of its cycle
  always begin
    @(negedge clk);
    #5;
    if (bus_rd && !bus_cmd) begin
      if (exp_q.size() == 0) begin
        check(bus_rdata, 'hEE, "unexpected read");
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(bus_rdata, e, t);
      end
    end
  end

  task automatic cmd(input logic [7:0] code);
    @(negedge clk);
    bus_cmd = 1'b1; bus_wr = 1'b1; bus_wdata = code;
    @(negedge clk);
    bus_cmd = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [7:0] b);
    @(negedge clk);
    bus_wr = 1'b1; bus_wdata = b;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] e, input string tag, input logic [NUM_EP-1:0] done = '0);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(tag);
    bus_rd = 1'b1; usb_done = done;
    @(negedge clk);
    bus_rd = 1'b0; usb_done = '0;
  endtask

  task automatic pulse_setup();
    @(negedge clk);
    usb_setup = 1'b1;
    @(negedge clk);
    usb_setup = 1'b0;
  endtask

  task automatic pulse_done(input int ep);
    @(negedge clk);
    usb_done[ep] = 1'b1;
    @(negedge clk);
    usb_done = '0;
  endtask

  initial begin
    #(20 * 20000);
    if (!over) begin
      over = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_cmd = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = '0; usb_setup = 1'b0; usb_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    #1 check(ep_irq, 0, "R1 irq after reset");
    cmd(8'h53);
    rd(8'h00, "R1 R3 status ep3 after reset");

    // R2 R8: processor write then read back, length prefix first
    cmd(8'h02);
    wr(8'h03); wr(8'h00); wr(8'hA1); wr(8'hB2); wr(8'hC3);
    cmd(8'h02);
    rd(8'h03, "R2 R8 len lo"); rd(8'h00, "R2 len hi");
    rd(8'hA1, "R2 byte1"); rd(8'hB2, "R2 byte2"); rd(8'hC3, "R2 byte3");
    cmd(8'h52);
    rd(8'h20, "R6 R3 buffer0 full");

    // R6: validate releases, toggles buffer and toggle bit
    cmd(8'h22);
    cmd(8'h52);
    rd(8'h12, "R6 after validate");
    cmd(8'h02);
    wr(8'h01); wr(8'h00); wr(8'h5A);
    cmd(8'h52);
    rd(8'h52, "R6 buffer1 full");
    cmd(8'h02);
    rd(8'h01, "R6 buffer1 len lo"); rd(8'h00, "R6 buffer1 len hi");
    rd(8'h5A, "R6 buffer1 data");

    // R5: stall and unstall
    cmd(8'h45); cmd(8'h55);
    rd(8'h80, "R5 stall set");
    cmd(8'h65); cmd(8'h55);
    rd(8'h00, "R5 stall cleared");

    // R5 R11: SETUP clears control stalls, sets setup, toggle, irq
    cmd(8'h41); cmd(8'h40);
    pulse_setup();
    #1 check(ep_irq[0], 1, "R11 irq0 after setup");
    cmd(8'h51);
    rd(8'h00, "R5 setup clears ep1 stall");
    cmd(8'h50);
    rd(8'h14, "R11 R5 ep0 status after setup");
    #1 check(ep_irq[0], 0, "R4 status read clears irq0");
    cmd(8'h50);
    rd(8'h10, "R10 setup flag cleared by read");

    // R4: completion irq, clear, and set winning over clear
    pulse_done(7);
    #1 check(ep_irq[7], 1, "R4 done sets irq7");
    cmd(8'h57);
    rd(8'h00, "R4 status ep7");
    #1 check(ep_irq[7], 0, "R4 read clears irq7");
    rd(8'h00, "R4 status ep7 again", 16'h0080);
    #1 check(ep_irq[7], 1, "R4 set wins over clear");

    // R7: DMA rolls from buffer 0 to buffer 1
    cmd(8'h13);
    for (int i = 0; i < 10; i++) wr(8'h10 + 8'(i));
    cmd(8'h53);
    rd(8'h60, "R7 both buffers full");
    cmd(8'h03);
    rd(8'h00, "R7 len lo"); rd(8'h00, "R7 len hi");
    rd(8'h10, "R7 buf0 byte0"); rd(8'h11, "R7 buf0 byte1"); rd(8'h12, "R7 buf0 byte2");
    cmd(8'h23);
    cmd(8'h03);
    rd(8'h00, "R7 len lo b1"); rd(8'h00, "R7 len hi b1");
    rd(8'h18, "R7 buf1 byte0"); rd(8'h19, "R7 buf1 byte1");

    // R9: data offset wraps inside the buffer
    cmd(8'h04);
    wr(8'h0A); wr(8'h00);
    for (int i = 0; i < 10; i++) wr(8'h80 + 8'(i));
    cmd(8'h04);
    rd(8'h0A, "R9 len lo"); rd(8'h00, "R9 len hi");
    rd(8'h88, "R9 wrapped byte0"); rd(8'h89, "R9 wrapped byte1"); rd(8'h82, "R9 byte2");

    // R10: SETUP during a processor read of endpoint 0
    cmd(8'h00);
    rd(8'h00, "R10 ep0 len lo");
    pulse_setup();
    cmd(8'h50);
    rd(8'h1C, "R10 overwrite set");
    cmd(8'h50);
    rd(8'h10, "R10 overwrite cleared");

    repeat (3) @(negedge clk);
    check(exp_q.size(), 0, "R1 all reads observed");
    if (!over) begin
      over = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule